// File: doc/BRIEF.md
# Eight-pin GPIO port with address-masked data access

This block is one general-purpose I/O port sitting on a simple synchronous register bus. Each pin can be an input or a driven output. It can also be handed over to a peripheral, which then supplies both the output value and the output enable for that pin. Data accesses take a per-pin mask from address bits [9:2]. Software can therefore set or clear any group of pins in a single bus write, with no read-modify-write of the data register.

Every input passes through a two-flop synchronizer. Separate per-pin registers then choose how a pin raises an interrupt:
- a latched single edge, with a chosen polarity;
- either edge;
- a live level, with a chosen active value.

A raw status and an enable-gated status can both be read. Latched edges are cleared by writing ones. The port interrupt is the OR of the enabled status bits.

Bus reads are combinational from the current address. A write takes effect at the clock edge where the write enable is sampled high. All storage resets to zero on a synchronous active-high reset.

Top module: `gpio_mport`

## Requirements
- R1: After reset all registers are zero: every pin is an input (pin_oe = 0), every pin is under software control, every status bit reads 0 and irq is low.
- R2: A write to the data window (address below 0x400) updates only the output bits whose bit is set in address bits [9:2]. The other output bits keep their value, and a mask of 0x00 changes nothing.
- R3: A read from the data window returns each pin's value ANDed with the address mask; unselected bits read 0. A pin's value is its output register bit when it is an output, and its synchronized input (two clocks behind pin_in) when it is an input.
- R4: The direction register at 0x400 holds one bit per pin (1 = output). Under software control, pin_oe equals this register.
- R5: The ownership register at 0x420 holds one bit per pin. For a pin whose bit is 1, pin_out and pin_oe come from periph_out and periph_oe; for a pin whose bit is 0, they come from the data and direction registers.
- R6: A pin whose bit in the sense register (0x404) is 0 detects edges. If its bit in the both-edge register (0x408) is 0, the polarity register (0x40C) selects the edge: 1 = rising, 0 = falling. A detected edge sets the pin's raw status bit (read at 0x414) on the third clock edge after pin_in changes. The bit stays set until it is cleared.
- R7: With its both-edge bit set, an edge-sensed pin latches on rising and on falling transitions.
- R8: A pin whose sense bit is 1 has a raw status that follows its synchronized level live, active high when its polarity bit is 1 and active low when it is 0. Clear writes do not affect it.
- R9: The enable register at 0x410 (1 = enabled) gates the status. The enabled status read at 0x418 equals raw AND enable, and irq is the OR of the enabled status bits.
- R10: Writing a 1 to a bit of the clear register at 0x41C clears that pin's latched edge. Writing 0 to a bit leaves it unchanged.
- R11: The configuration registers read back their written value at their own offsets. Writes to the status offsets 0x414 and 0x418 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W (32) | Write data; only the low NPINS bits are used |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| pin_in | input | NPINS (8) | Asynchronous pin levels from the pads |
| pin_out | output | NPINS (8) | Value driven toward the pads |
| pin_oe | output | NPINS (8) | Output enable toward the pads |
| periph_out | input | NPINS (8) | Peripheral output value for handed-over pins |
| periph_oe | input | NPINS (8) | Peripheral output enable for handed-over pins |
| irq | output | 1 | Port interrupt, OR of the enabled status bits |

## Verification
The bench builds the block with its defaults: NPINS = 8, ADDR_W = 12 and DATA_W = 32. These place the pin mask at address bits [9:2] and the control window at 0x400, so the 0xC3-style partial masks and single-pin writes can be driven directly. A behavioural model follows the synchronizer delay, the edge latches and the live levels on every clock. That model exposes clear-versus-set races and mixed edge/level configurations on different pins of the same port.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;

    // Control offsets relative to the start of the control window.
    localparam int OFS_DIR   = 'h00;
    localparam int OFS_SENSE = 'h04;
    localparam int OFS_BOTH  = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_EN    = 'h10;
    localparam int OFS_RAW   = 'h14;
    localparam int OFS_MIS   = 'h18;
    localparam int OFS_CLR   = 'h1C;
    localparam int OFS_MODE  = 'h20;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_POL,
        SEL_EN, SEL_RAW, SEL_MIS, SEL_CLR, SEL_MODE
    } reg_sel_e;

    // Per-pin trigger configuration.
    typedef struct packed {
        logic level;   // 1: level sensed, 0: edge sensed
        logic both;    // any transition
        logic pol;     // rising / active-high when 1
    } pin_trig_t;

    function automatic logic edge_hit(pin_trig_t c, logic rise, logic fall);
        if (c.level)     return 1'b0;
        else if (c.both) return rise | fall;
        else             return c.pol ? rise : fall;
    endfunction

    function automatic logic level_active(pin_trig_t c, logic lvl);
        return lvl ~^ c.pol;
    endfunction

endpackage

// File: rtl/gpio_mport_sync.sv
module gpio_mport_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    logic [NPINS-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_mport_irq.sv
module gpio_mport_irq
    import gpio_mport_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] sense_q,
    input  logic [NPINS-1:0] both_q,
    input  logic [NPINS-1:0] pol_q,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] raw
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_trig_t cfg;
        logic      latch_q;

        assign cfg = '{level: sense_q[i], both: both_q[i], pol: pol_q[i]};
        assign hit[i] = edge_hit(cfg, rise[i], fall[i]);

        // A new edge in the same cycle as a clear keeps the bit set.
        always_ff @(posedge clk) begin
            if (rst) latch_q <= 1'b0;
            else     latch_q <= (latch_q & ~clr_vec[i]) | hit[i];
        end

        assign raw[i] = cfg.level ? level_active(cfg, lvl[i]) : latch_q;
    end
endmodule

// File: rtl/gpio_mport_regs.sv
module gpio_mport_regs
    import gpio_mport_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  lvl,
    input  logic [NPINS-1:0]  raw,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  mode_q,
    output logic [NPINS-1:0]  clr_vec
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + NPINS - 1;
    localparam int OFS_W   = MASK_HI + 1;
    localparam int PAGE_W  = ADDR_W - OFS_W;

    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic [NPINS-1:0]  msk, wd, pin_val;
    reg_sel_e          sel;
    logic              unused_bus;

    assign page = bus_addr[ADDR_W-1:OFS_W];
    assign ofs  = bus_addr[OFS_W-1:0];
    assign msk  = bus_addr[MASK_HI:MASK_LO];
    assign wd   = bus_wdata[NPINS-1:0];
    assign unused_bus = ^{bus_addr[MASK_LO-1:0], bus_wdata[DATA_W-1:NPINS]};

    always_comb begin
        sel = SEL_NONE;
        if (page == '0) begin
            sel = SEL_DATA;
        end else if (page == PAGE_W'(1)) begin
            case (ofs)
                OFS_W'(OFS_DIR):   sel = SEL_DIR;
                OFS_W'(OFS_SENSE): sel = SEL_SENSE;
                OFS_W'(OFS_BOTH):  sel = SEL_BOTH;
                OFS_W'(OFS_POL):   sel = SEL_POL;
                OFS_W'(OFS_EN):    sel = SEL_EN;
                OFS_W'(OFS_RAW):   sel = SEL_RAW;
                OFS_W'(OFS_MIS):   sel = SEL_MIS;
                OFS_W'(OFS_CLR):   sel = SEL_CLR;
                OFS_W'(OFS_MODE):  sel = SEL_MODE;
                default:           sel = SEL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
            mode_q  <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_DATA:  data_q  <= (data_q & ~msk) | (wd & msk);
                SEL_DIR:   dir_q   <= wd;
                SEL_SENSE: sense_q <= wd;
                SEL_BOTH:  both_q  <= wd;
                SEL_POL:   pol_q   <= wd;
                SEL_EN:    en_q    <= wd;
                SEL_MODE:  mode_q  <= wd;
                default:   ;
            endcase
        end
    end

    assign clr_vec = (bus_we && sel == SEL_CLR) ? wd : '0;
    assign pin_val = (dir_q & data_q) | (~dir_q & lvl);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA:  bus_rdata[NPINS-1:0] = pin_val & msk;
            SEL_DIR:   bus_rdata[NPINS-1:0] = dir_q;
            SEL_SENSE: bus_rdata[NPINS-1:0] = sense_q;
            SEL_BOTH:  bus_rdata[NPINS-1:0] = both_q;
            SEL_POL:   bus_rdata[NPINS-1:0] = pol_q;
            SEL_EN:    bus_rdata[NPINS-1:0] = en_q;
            SEL_RAW:   bus_rdata[NPINS-1:0] = raw;
            SEL_MIS:   bus_rdata[NPINS-1:0] = raw & en_q;
            SEL_MODE:  bus_rdata[NPINS-1:0] = mode_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mport.sv
module gpio_mport #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic              irq
);
    logic [NPINS-1:0] lvl, rise, fall;
    logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, mask_q, mode_q;
    logic [NPINS-1:0] clr_vec, edge_hit, raw_st;

    gpio_mport_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    gpio_mport_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lvl(lvl), .raw(raw_st),
        .data_q(data_q), .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .en_q(mask_q), .mode_q(mode_q), .clr_vec(clr_vec)
    );

    gpio_mport_irq #(.NPINS(NPINS)) u_irq (
        .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall),
        .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q),
        .clr_vec(clr_vec), .hit(edge_hit), .raw(raw_st)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        assign pin_out[i] = mode_q[i] ? periph_out[i] : data_q[i];
        assign pin_oe[i]  = mode_q[i] ? periph_oe[i]  : dir_q[i];
    end

    assign irq = |(raw_st & mask_q);
endmodule

// File: rtl/gpio_mport_chk.sv
module gpio_mport_chk #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  mode_q,
    input logic [NPINS-1:0]  sense_q,
    input logic [NPINS-1:0]  raw_st,
    input logic [NPINS-1:0]  edge_hit,
    input logic [NPINS-1:0]  clr_vec,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  periph_out,
    input logic              irq
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + NPINS - 1;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && !irq && raw_st == '0));

    a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[ADDR_W-1:MASK_HI+1] == '0)
        |=> ((data_q ^ $past(data_q)) & ~$past(bus_addr[MASK_HI:MASK_LO])) == '0);

    a_r5_periph_owns: assert property (@(posedge clk) disable iff (rst)
        (mode_q == '1) |-> (pin_out == periph_out));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        a_r10_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !edge_hit[i] && !sense_q[i]) |=> (!raw_st[i] || sense_q[i]));

        a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
            (!sense_q[i] && raw_st[i] && !clr_vec[i]) |=> (raw_st[i] || sense_q[i]));
    end
endmodule

bind gpio_mport gpio_mport_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .data_q(data_q), .mask_q(mask_q), .mode_q(mode_q), .sense_q(sense_q),
    .raw_st(raw_st), .edge_hit(edge_hit), .clr_vec(clr_vec),
    .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out), .irq(irq)
);

// File: tb/gpio_mport_tb.sv
`timescale 1ns/1ps
module gpio_mport_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0, pin_out, pin_oe, periph_out = '0, periph_oe = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_mport u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .irq(irq)
    );

    // Behavioural reference state.
    logic [7:0] m_data, m_dir, m_sense, m_both, m_pol, m_en, m_mode;
    logic [7:0] m_s1, m_s2, m_s3, m_edge;

    function automatic logic [7:0] m_raw();
        return (m_sense & ~(m_pol ^ m_s2)) | (~m_sense & m_edge);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] trig, clr, msk, wd;
        if (rst) begin
            {m_data, m_dir, m_sense, m_both, m_pol, m_en, m_mode} = '0;
            {m_s1, m_s2, m_s3, m_edge} = '0;
        end else begin
            wd   = bus_wdata[7:0];
            trig = ~m_sense & ((m_both & (m_s2 ^ m_s3)) |
                   (~m_both & ((m_pol & m_s2 & ~m_s3) | (~m_pol & ~m_s2 & m_s3))));
            clr  = (bus_we && bus_addr == 12'h41C) ? wd : 8'h00;
            m_edge = (m_edge & ~clr) | trig;
            if (bus_we) begin
                if (bus_addr < 12'h400) begin
                    msk = bus_addr[9:2];
                    m_data = (m_data & ~msk) | (wd & msk);
                end else begin
                    case (bus_addr)
                        12'h400: m_dir   = wd;
                        12'h404: m_sense = wd;
                        12'h408: m_both  = wd;
                        12'h40C: m_pol   = wd;
                        12'h410: m_en    = wd;
                        12'h420: m_mode  = wd;
                        default: ;
                    endcase
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
        #3;
        if (!done) begin
            check(pin_out == ((m_mode & periph_out) | (~m_mode & m_data)),
                  "R5 pin_out per clock", pin_out, (m_mode & periph_out) | (~m_mode & m_data));
            check(pin_oe == ((m_mode & periph_oe) | (~m_mode & m_dir)),
                  "R4 pin_oe per clock", pin_oe, (m_mode & periph_oe) | (~m_mode & m_dir));
            check(irq == |(m_raw() & m_en), "R9 irq per clock", irq, |(m_raw() & m_en));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {24'h0, d}; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == {24'h0, exp}, tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] dat(input logic [7:0] m);
        return {2'b00, m, 2'b00};
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(12'h400, 8'h00, "R1 dir after reset");
        rd(12'h414, 8'h00, "R1 raw after reset");
        rd(12'h420, 8'h00, "R1 mode after reset");
        check(pin_oe == 8'h00 && irq == 1'b0, "R1 outputs after reset", {pin_oe, 7'b0, irq}, 0);

        // R4 direction
        wr(12'h400, 8'hFF);
        rd(12'h400, 8'hFF, "R4 dir readback");
        check(pin_oe == 8'hFF, "R4 pin_oe all outputs", pin_oe, 8'hFF);

        // R2 masked writes
        wr(dat(8'hFF), 8'hA5);
        wr(dat(8'h0F), 8'hFF);
        check(pin_out == 8'hAF, "R2 low nibble written", pin_out, 8'hAF);
        wr(dat(8'h00), 8'h00);
        check(pin_out == 8'hAF, "R2 empty mask no change", pin_out, 8'hAF);
        rd(dat(8'hC3), 8'h83, "R3 partial mask of outputs");

        // R3 inputs mixed with outputs
        wr(12'h400, 8'h0F);
        pin_in = 8'h81;
        idle(4);
        rd(dat(8'hFF), 8'h8F, "R3 full mask mixed");
        rd(dat(8'hC3), 8'h83, "R3 mask C3");

        // R5 peripheral ownership
        periph_out = 8'h3C; periph_oe = 8'h55;
        wr(12'h420, 8'hF0);
        #1;
        check(pin_out == 8'h3F, "R5 pin_out mixed owners", pin_out, 8'h3F);
        check(pin_oe == 8'h5F, "R5 pin_oe mixed owners", pin_oe, 8'h5F);
        wr(12'h420, 8'h00);

        // Edge detection
        wr(12'h400, 8'h00);
        pin_in = 8'h00;
        idle(4);
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h00, "R10 clear all");
        wr(12'h40C, 8'h01);
        wr(12'h408, 8'h04);
        pin_in = 8'h07;
        idle(4);
        rd(12'h414, 8'h05, "R6 rising latched, falling-mode pin quiet; R7 both");
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h00, "R10 clear after rise");
        pin_in = 8'h00;
        idle(4);
        rd(12'h414, 8'h06, "R6 falling latched; R7 both on fall");
        wr(12'h41C, 8'h00);
        rd(12'h414, 8'h06, "R10 zero write no effect");

        // R9 enable gating
        wr(12'h410, 8'h04);
        rd(12'h418, 8'h04, "R9 enabled status");
        #1;
        check(irq == 1'b1, "R9 irq asserted", irq, 1);
        wr(12'h410, 8'h01);
        rd(12'h418, 8'h00, "R9 enabled status masked");
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(12'h41C, 8'h02);
        rd(12'h414, 8'h04, "R10 single bit clear");

        // R11 status offsets ignore writes, readbacks
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'hFF);
        rd(12'h414, 8'h04, "R11 raw ignores writes");
        rd(12'h404, 8'h00, "R11 sense readback");
        rd(12'h408, 8'h04, "R11 both readback");
        rd(12'h40C, 8'h01, "R11 polarity readback");
        rd(12'h410, 8'h01, "R11 enable readback");

        // R8 level sensing
        wr(12'h41C, 8'hFF);
        wr(12'h40C, 8'h11);
        wr(12'h404, 8'h30);
        rd(12'h414, 8'h20, "R8 active-low pin asserted at low level");
        pin_in = 8'h10;
        idle(4);
        rd(12'h414, 8'h30, "R8 both level pins active");
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h30, "R8 clear does not affect level");
        wr(12'h410, 8'h30);
        #1;
        check(irq == 1'b1, "R9 irq from level", irq, 1);
        pin_in = 8'h20;
        idle(4);
        rd(12'h414, 8'h00, "R8 level released");
        check(irq == 1'b0, "R8 irq released", irq, 0);

        idle(2);
        finish_run();
    end
endmodule